// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the protocol and control logic of a byte-wide serial memory that sits on a two-wire open-drain bus. The bus clock and data lines are taken in as plain inputs. The block pulls data low through an output-enable, and the pad and pull-up are outside it. Both lines pass through two-flop synchronisers on a system clock that runs at least eight times faster than the bus clock. Start, Stop and the clock edges are found from the synchronised levels.

A host selects the device with an address byte made of a fixed prefix, two strap bits taken from pins and a read/write flag. A write loads a two-byte word address and then any number of data bytes. The data bytes go into a page buffer and reach the array only after the Stop, during a self-timed write cycle whose length is a parameter. During that cycle the device ignores its own address, so the host can poll until it is acknowledged again. Reads start at the internal address counter. A write that is stopped after its word address, followed by a repeated Start in read mode, gives a random read. A write-lock input keeps data bytes out of the array.

Top module: `tw_mem_slave`

## Requirements
- R1: After reset the data output-enable is low (SDA released) and the block waits for a Start.
- R2: An address byte is claimed only when bits 7..3 equal 10100 and bits 2..1 equal the strap pins (bit 2 = strap[1], bit 1 = strap[0]). Bit 0 is 1 for read and 0 for write. Any other address byte gets no acknowledge: SDA stays released in the ninth clock.
- R3: Every byte of a claimed write (address, both word-address bytes, data) is acknowledged by holding SDA low during the ninth clock. The data output-enable changes only while SCL is low.
- R4: The word address is two bytes, high byte first, MSB first within each byte. Only the low MEM_AW bits of the 16 are used (default 11, a 2048-byte array). Higher bits are ignored.
- R5: Data bytes of a write land at the loaded address and then at successive addresses. The low 6 bits wrap inside the 64-byte page, so a later byte overwrites an earlier one at the same page offset. Nothing reaches the array until the Stop.
- R6: For WR_CYCLES system clocks after a Stop that ends a write with at least one data byte, the device's own address byte is not acknowledged. After that it is acknowledged again.
- R7: While the write-lock input is high, data bytes are still acknowledged and still advance the address counter, but the array keeps its contents and no write cycle (no busy period) follows the Stop.
- R8: A write-mode address and a word address, followed by a repeated Start and a read-mode address, return data from that word address.
- R9: A read that starts without a new word address returns the location after the last byte written or read.
- R10: A read keeps sending successive bytes while the master acknowledges them, wrapping from the last array address to 0. After a master NACK the block releases SDA and waits for a Start.
- R11: A Start at any bit position aborts the current transfer and the next byte is taken as an address byte. Data bytes of a write that a Start ends, without a Stop, are discarded and start no write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | High pulls the data line low |
| strap_i | input | 2 | Pin-strapped device address bits |
| wr_lock_i | input | 1 | Write lock: high keeps data out of the array |

## Verification
The bench goes after the page wrap: if the page offset carried into the upper address bits, the bytes written past the page end would land in the next page, and the readback of the page would show the old data at the low offsets. It polls straight after a Stop to prove the busy NACK; a design that acknowledged early would hand the host a device that is still writing. It checks that a locked write and a write aborted by a repeated Start both leave old data in place and start no busy period. It reads across the top of the array and cuts an address byte off after three bits, where a counter that failed to wrap or to resynchronise would return wrong bytes or miss the next address.

// File: rtl/tw_mem_pkg.sv
package tw_mem_pkg;

    localparam logic [4:0] DEV_PREFIX = 5'b10100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RXACK,
        ST_TX,
        ST_TXACK
    } phase_e;

    typedef enum logic [1:0] {
        K_DEV,
        K_AHI,
        K_ALO,
        K_DATA
    } field_e;

endpackage

// File: rtl/tw_bus_sync.sv
module tw_bus_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic [2:0] scl;
        logic [2:0] sda;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.scl = {s_q.scl[1:0], scl_i};
        s_d.sda = {s_q.sda[1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign scl_o      = s_q.scl[1];
    assign sda_o      = s_q.sda[1];
    assign scl_rise_o = s_q.scl[1] & ~s_q.scl[2];
    assign scl_fall_o = ~s_q.scl[1] & s_q.scl[2];
    assign start_o    = s_q.scl[1] & s_q.scl[2] & s_q.sda[2] & ~s_q.sda[1];
    assign stop_o     = s_q.scl[1] & s_q.scl[2] & ~s_q.sda[2] & s_q.sda[1];

endmodule

// File: rtl/tw_wr_timer.sv
module tw_wr_timer #(
    parameter int WR_CYCLES = 2000,
    parameter int PAGE_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              busy_o,
    output logic              commit_o,
    output logic [PAGE_W-1:0] idx_o
);

    localparam int PAGE = 1 << PAGE_W;
    localparam int CW   = $clog2(WR_CYCLES + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (start_i) begin
            t_d.busy = 1'b1;
            t_d.cnt  = '0;
        end else if (t_q.busy) begin
            if (t_q.cnt == CW'(WR_CYCLES - 1)) begin
                t_d.busy = 1'b0;
            end else begin
                t_d.cnt = t_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign busy_o   = t_q.busy;
    assign commit_o = t_q.busy && (t_q.cnt < CW'(PAGE));
    assign idx_o    = t_q.cnt[PAGE_W-1:0];

    // R6
    busy_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !t_q.busy);

    // R6
    cycle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.busy |-> (t_q.cnt < CW'(WR_CYCLES)));

endmodule

// File: rtl/tw_page_buf.sv
module tw_page_buf #(
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              we_i,
    input  logic [PAGE_W-1:0] widx_i,
    input  logic [7:0]        wdata_i,
    input  logic [PAGE_W-1:0] ridx_i,
    output logic [7:0]        rdata_o,
    output logic              rvalid_o
);

    localparam int PAGE = 1 << PAGE_W;

    logic [7:0]      data_d [PAGE];
    logic [7:0]      data_q [PAGE];
    logic [PAGE-1:0] vld_d, vld_q;

    always_comb begin
        data_d = data_q;
        vld_d  = vld_q;
        if (clr_i) begin
            vld_d = '0;
        end else if (we_i) begin
            data_d[widx_i] = wdata_i;
            vld_d[widx_i]  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q <= vld_d;
        end
    end

    always_ff @(posedge clk) begin
        data_q <= data_d;
    end

    assign rdata_o  = data_q[ridx_i];
    assign rvalid_o = vld_q[ridx_i];

endmodule

// File: rtl/tw_mem_array.sv
module tw_mem_array #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [7:0]    wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);

    localparam int DEPTH = 1 << AW;

    logic [7:0] mem_q [DEPTH];
    logic [7:0] rd_q;

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
        rd_q <= mem_q[raddr_i];
    end

    assign rdata_o = rd_q;

endmodule

// File: rtl/tw_mem_slave.sv
module tw_mem_slave #(
    parameter int MEM_AW    = 11,
    parameter int PAGE_W    = 6,
    parameter int WR_CYCLES = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [1:0] strap_i,
    input  logic       wr_lock_i
);
    import tw_mem_pkg::*;

    localparam int HI_W = MEM_AW - 8;

    typedef struct packed {
        phase_e            st;
        field_e            kind;
        logic [3:0]        cnt;
        logic [7:0]        sh;
        logic              oe;
        logic              rw;
        logic              mack;
        logic              pend;
        logic [HI_W-1:0]   hi;
        logic [MEM_AW-1:0] addr;
    } ctl_t;

    ctl_t r_d, r_q;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, ev_start, ev_stop;
    logic wc_start, wc_busy, wc_commit;
    logic [PAGE_W-1:0] wc_idx;
    logic pb_clr, pb_we, pb_rvalid;
    logic [7:0] pb_rdata, mem_rdata;
    logic [MEM_AW-1:0] page_inc, mem_waddr;
    logic mem_we;

    tw_bus_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_o     (scl_lvl),
        .sda_o     (sda_lvl),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall),
        .start_o   (ev_start),
        .stop_o    (ev_stop)
    );

    tw_wr_timer #(.WR_CYCLES(WR_CYCLES), .PAGE_W(PAGE_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (wc_start),
        .busy_o  (wc_busy),
        .commit_o(wc_commit),
        .idx_o   (wc_idx)
    );

    tw_page_buf #(.PAGE_W(PAGE_W)) u_page (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (pb_clr),
        .we_i    (pb_we),
        .widx_i  (r_q.addr[PAGE_W-1:0]),
        .wdata_i (r_q.sh),
        .ridx_i  (wc_idx),
        .rdata_o (pb_rdata),
        .rvalid_o(pb_rvalid)
    );

    assign mem_we    = wc_commit && pb_rvalid;
    assign mem_waddr = {r_q.addr[MEM_AW-1:PAGE_W], wc_idx};

    tw_mem_array #(.AW(MEM_AW)) u_array (
        .clk    (clk),
        .we_i   (mem_we),
        .waddr_i(mem_waddr),
        .wdata_i(pb_rdata),
        .raddr_i(r_q.addr),
        .rdata_o(mem_rdata)
    );

    assign page_inc = {r_q.addr[MEM_AW-1:PAGE_W], r_q.addr[PAGE_W-1:0] + PAGE_W'(1)};

    always_comb begin
        r_d      = r_q;
        wc_start = 1'b0;
        pb_clr   = 1'b0;
        pb_we    = 1'b0;
        if (ev_start) begin
            r_d.st   = ST_RX;
            r_d.kind = K_DEV;
            r_d.cnt  = '0;
            r_d.oe   = 1'b0;
            r_d.pend = 1'b0;
        end else if (ev_stop) begin
            r_d.st   = ST_IDLE;
            r_d.oe   = 1'b0;
            r_d.pend = 1'b0;
            wc_start = r_q.pend;
        end else begin
            case (r_q.st)
                ST_RX: begin
                    if (scl_rise) begin
                        r_d.sh  = {r_q.sh[6:0], sda_lvl};
                        r_d.cnt = r_q.cnt + 4'd1;
                    end else if (scl_fall && r_q.cnt == 4'd8) begin
                        r_d.st = ST_RXACK;
                        r_d.oe = 1'b1;
                        case (r_q.kind)
                            K_DEV: begin
                                if (r_q.sh[7:3] == DEV_PREFIX && r_q.sh[2:1] == strap_i && !wc_busy) begin
                                    r_d.rw = r_q.sh[0];
                                end else begin
                                    r_d.st = ST_IDLE;
                                    r_d.oe = 1'b0;
                                end
                            end
                            K_AHI: r_d.hi = r_q.sh[HI_W-1:0];
                            K_ALO: begin
                                r_d.addr = {r_q.hi, r_q.sh};
                                pb_clr   = 1'b1;
                            end
                            default: begin
                                if (!wr_lock_i) begin
                                    pb_we    = 1'b1;
                                    r_d.pend = 1'b1;
                                end
                                r_d.addr = page_inc;
                            end
                        endcase
                    end
                end
                ST_RXACK: begin
                    if (scl_fall) begin
                        r_d.oe  = 1'b0;
                        r_d.cnt = '0;
                        if (r_q.kind == K_DEV && r_q.rw) begin
                            r_d.st   = ST_TX;
                            r_d.sh   = mem_rdata;
                            r_d.oe   = ~mem_rdata[7];
                            r_d.addr = r_q.addr + MEM_AW'(1);
                        end else begin
                            r_d.st = ST_RX;
                            case (r_q.kind)
                                K_DEV:   r_d.kind = K_AHI;
                                K_AHI:   r_d.kind = K_ALO;
                                default: r_d.kind = K_DATA;
                            endcase
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (r_q.cnt == 4'd7) begin
                            r_d.st = ST_TXACK;
                            r_d.oe = 1'b0;
                        end else begin
                            r_d.cnt = r_q.cnt + 4'd1;
                            r_d.sh  = {r_q.sh[6:0], 1'b0};
                            r_d.oe  = ~r_q.sh[6];
                        end
                    end
                end
                ST_TXACK: begin
                    if (scl_rise) begin
                        r_d.mack = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (r_q.mack) begin
                            r_d.st   = ST_TX;
                            r_d.cnt  = '0;
                            r_d.sh   = mem_rdata;
                            r_d.oe   = ~mem_rdata[7];
                            r_d.addr = r_q.addr + MEM_AW'(1);
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end
                end
                default: r_d.oe = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe_o = r_q.oe;

    // R3
    sda_change_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.oe != $past(r_q.oe)) |-> !scl_lvl);

    // R6
    busy_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wc_busy) |-> $past(ev_stop));

    // R8
    tx_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_TX) |-> r_q.rw);

    // R5
    commit_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (r_q.st == ST_IDLE || r_q.st == ST_RX));

endmodule

// File: tb/tw_mem_slave_tb.sv
module tw_mem_slave_tb_top;

    localparam int AW  = 11;
    localparam int Q   = 8;
    localparam int H   = 16;
    localparam logic [7:0] DEVW = 8'hA4;
    localparam logic [7:0] DEVR = 8'hA5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_oe;
    logic wr_lock = 1'b0;
    logic sda_bus;

    assign sda_bus = !(m_low || sda_oe);

    always #2 clk = ~clk;

    tw_mem_slave #(.MEM_AW(AW), .PAGE_W(6), .WR_CYCLES(2000)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_bus),
        .sda_oe_o (sda_oe),
        .strap_i  (2'b10),
        .wr_lock_i(wr_lock)
    );

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;
    logic [7:0] mdl [0:2047];
    bit kn [0:2047];
    int cur = 0;

    task automatic hp(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int pg_next(input int a);
        return (a & ~63) | ((a + 1) & 63);
    endfunction

    task automatic m_bit(input bit b);
        m_low = !b;
        hp(Q); scl = 1'b1; hp(H); scl = 1'b0; hp(Q);
    endtask

    task automatic m_start();
        if (!scl) begin
            m_low = 1'b0; hp(Q); scl = 1'b1; hp(H);
        end
        m_low = 1'b1; hp(H); scl = 1'b0; hp(Q);
    endtask

    task automatic m_stop();
        m_low = 1'b1; hp(Q); scl = 1'b1; hp(H); m_low = 1'b0; hp(H);
    endtask

    task automatic m_send(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) m_bit(b[i]);
        m_low = 1'b0;
        hp(Q); scl = 1'b1; hp(H/2); ack = !sda_bus; hp(H/2); scl = 1'b0; hp(Q);
    endtask

    task automatic m_recv(input bit mack, output logic [7:0] d);
        m_low = 1'b0;
        d = 8'h00;
        for (int i = 0; i < 8; i++) begin
            hp(Q); scl = 1'b1; hp(H/2); d = {d[6:0], sda_bus}; hp(H/2); scl = 1'b0; hp(Q);
        end
        m_bit(!mack);
        m_low = 1'b0;
    endtask

    task automatic wait_ready(output int polls);
        bit a;
        polls = 0;
        a = 1'b0;
        while (!a && polls < 60) begin
            m_start(); m_send(DEVW, a); polls++; m_stop();
        end
    endtask

    // start, address, word address and n data bytes; the caller ends the transfer
    task automatic m_write(input logic [15:0] wa, input int n, input bit commit, output int nacks);
        bit a;
        logic [7:0] d;
        nacks = 0;
        m_start();
        m_send(DEVW, a); if (!a) nacks++;
        m_send(wa[15:8], a); if (!a) nacks++;
        m_send(wa[7:0], a); if (!a) nacks++;
        cur = int'(wa) & 2047;
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            m_send(d, a); if (!a) nacks++;
            if (commit) begin mdl[cur] = d; kn[cur] = 1'b1; end
            cur = pg_next(cur);
        end
    endtask

    task automatic read_bytes(input int n, input string req);
        logic [7:0] d;
        for (int i = 0; i < n; i++) begin
            m_recv(i != n - 1, d);
            if (kn[cur]) chk(d == mdl[cur], req, int'(d), int'(mdl[cur]));
            cur = (cur + 1) & 2047;
        end
        // R10: SDA released after the master NACK
        chk(sda_oe == 1'b0, "R10", int'(sda_oe), 0);
        m_stop();
    endtask

    task automatic m_rread(input logic [15:0] wa, input int n, input string req);
        bit a;
        int bad;
        bad = 0;
        m_start();
        m_send(DEVW, a); if (!a) bad++;
        m_send(wa[15:8], a); if (!a) bad++;
        m_send(wa[7:0], a); if (!a) bad++;
        m_start();
        m_send(DEVR, a); if (!a) bad++;
        chk(bad == 0, "R8", bad, 0);
        cur = int'(wa) & 2047;
        read_bytes(n, req);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual 1 expected 0");
            finish_run();
        end
    end

    initial begin
        int nk, p;
        bit a;
        logic [7:0] d;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 2048; i++) kn[i] = 1'b0;
        hp(5);
        rst_n = 1'b1;
        hp(10);
        // R1
        chk(sda_oe == 1'b0, "R1", int'(sda_oe), 0);

        // R3, R4: two bytes through a word address with ignored high bits
        m_write(16'h3923, 2, 1'b1, nk);
        chk(nk == 0, "R3", nk, 0);
        m_stop();
        // R6: busy right after the Stop
        m_start(); m_send(DEVW, a); m_stop();
        chk(!a, "R6", int'(a), 0);
        wait_ready(p);
        chk(p > 1 && p < 60, "R6", p, 2);
        // R4, R8: same location through a different high byte
        m_rread(16'h0123, 1, "R4");
        // R9: current-address read gives 0x124
        m_start(); m_send(DEVR, a);
        chk(a, "R9", int'(a), 1);
        read_bytes(1, "R9");

        // R5: page write that wraps inside the page
        m_write(16'h0200 + 16'd60, 68, 1'b1, nk);
        chk(nk == 0, "R5", nk, 0);
        m_stop();
        wait_ready(p);
        m_rread(16'h0200, 64, "R5");

        // R10: sequential read across the array end
        m_write(16'h0000, 1, 1'b1, nk); m_stop(); wait_ready(p);
        m_write(16'h07FE, 2, 1'b1, nk); m_stop(); wait_ready(p);
        m_rread(16'h07FE, 3, "R10");

        // R2: strap and prefix mismatches
        m_start(); m_send({5'b10100, 2'b01, 1'b0}, a); m_stop();
        chk(!a, "R2", int'(a), 0);
        m_start(); m_send(8'hB4, a); m_stop();
        chk(!a, "R2", int'(a), 0);
        m_start(); m_send(DEVW, a); m_stop();
        chk(a, "R2", int'(a), 1);

        // R7: locked write, acknowledged, not committed, no busy
        wr_lock = 1'b1;
        m_write(16'h0123, 3, 1'b0, nk);
        chk(nk == 0, "R7", nk, 0);
        m_stop();
        wr_lock = 1'b0;
        m_start(); m_send(DEVW, a); m_stop();
        chk(a, "R7", int'(a), 1);
        m_rread(16'h0123, 1, "R7");

        // R11: Start after three bits of an address byte
        m_start(); m_bit(1'b1); m_bit(1'b0); m_bit(1'b1);
        m_start(); m_send(DEVW, a); m_stop();
        chk(a, "R11", int'(a), 1);

        // R11: write aborted by a repeated Start is discarded
        m_write(16'h0050, 1, 1'b1, nk); m_stop(); wait_ready(p);
        m_write(16'h0050, 1, 1'b0, nk);
        m_start(); m_send(DEVR, a);
        chk(a, "R11", int'(a), 1);
        read_bytes(1, "R11");
        m_start(); m_send(DEVW, a); m_stop();
        chk(a, "R11", int'(a), 1);
        m_rread(16'h0050, 1, "R11");

        // random mix of writes and reads checked against the model
        for (int it = 0; it < 8; it++) begin
            logic [15:0] ra;
            int n;
            ra = 16'($urandom);
            n  = 1 + int'($urandom % 5);
            if ($urandom % 2 == 0) begin
                m_write(ra, n, 1'b1, nk);
                chk(nk == 0, "R5", nk, 0);
                m_stop();
                wait_ready(p);
            end else if ($urandom % 2 == 0) begin
                m_rread(ra, n, "R8");
            end else begin
                m_start(); m_send(DEVR, a);
                chk(a, "R9", int'(a), 1);
                read_bytes(n, "R9");
            end
        end

        d = 8'h00;
        if (d != 8'h00) nchk++;
        done = 1'b1;
        finish_run();
    end

endmodule